// File: doc/BRIEF.md
# Multi-Group Channel Control Register File

This block is the host-visible control store for sixteen channel groups. Each group owns a window of 64 byte-wide scratch/control locations. Each group also owns one main control byte, from which three per-group settings are decoded: power-up, companding law and PCM coding. The host reaches everything through a simple synchronous bus with separate write and read strobes. A read returns its byte one clock after the strobe, and that byte stays on the bus until the next read.

Group 0's main byte carries three global bits. The first is a broadcast bit: while it is set, every group's window answers at group 0's addresses, so a single write initializes all sixteen groups at the same offset. The second is an output-enable bit, which is ANDed with an external pin. The third is a master interrupt mask. Each group feeds two raw tone-detector interrupts into the block. Each of these has its own mask bit in that group's main byte. All unmasked interrupts are merged into one registered, active-high interrupt line.

Top module: `ctl_regfile_top`

## Requirements
- R1: After a synchronous active-low reset, every window byte and every main byte is 0x00, and `host_rdata`, `irq_out`, `oe_out` and all per-group decoded outputs are 0.
- R2: With broadcast off, byte `o` of group `g` sits at address `g*0x40 + o`. A read strobe returns that byte on `host_rdata` one clock later, and the value holds until the next read strobe.
- R3: Main byte `g` sits at address `0x400 + g`. Its bit 0 drives `pwr_up[g]`, bit 1 drives `law_alaw[g]` (1 = A-law, 0 = μ-law), and bit 2 drives `fmt_g711[g]` (1 = G.711 coding, 0 = sign-magnitude).
- R4: While bit 7 of main byte 0 is set, a write to 0x000–0x03F stores the byte at that offset in all sixteen groups.
- R5: While bit 7 of main byte 0 is set, writes to 0x040–0x3FF are ignored and reads from them return 0. Reads from 0x000–0x03F return group 0's bytes.
- R6: For groups 1–15, bits 7:5 of the main byte are not stored and read back as 0. Setting them has no broadcast, enable or masking effect.
- R7: `oe_out` is high exactly when bit 6 of main byte 0 and `oe_pin` are both high.
- R8: `irq_out` is the one-cycle-registered OR of every `tone_a_irq[g]` not masked by bit 3 of main byte `g` and every `tone_b_irq[g]` not masked by bit 4 of main byte `g` (a set bit masks).
- R9: While bit 5 of main byte 0 is set, `irq_out` is 0 whatever the detector inputs and per-detector masks are.
- R10: Addresses 0x410–0x7FF map to nothing: writes there change no register and reads return 0.
- R11: When a read and a write hit the same address in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 11 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| oe_pin | input | 1 | External output-enable pin |
| oe_out | output | 1 | Combined data-output enable |
| tone_a_irq | input | 16 | Raw detector A interrupts, one per group |
| tone_b_irq | input | 16 | Raw detector B interrupts, one per group |
| irq_out | output | 1 | Merged, masked, registered interrupt |
| pwr_up | output | 16 | Per-group power-up control |
| law_alaw | output | 16 | Per-group law select, 1 = A-law |
| fmt_g711 | output | 16 | Per-group coding select, 1 = G.711 |

## Verification
The bench goes after the broadcast edges. Writes at group 0's offsets must land in every group, and higher windows must go dark while the bit is set and come back intact afterwards. A design that mixed these up would either leak a broadcast write into only one group or corrupt other groups with ignored writes. The bench sets the global bit positions in a non-zero group's main byte; a design that decoded them per group would start broadcasting, enabling or masking by mistake. It also exercises the per-detector masks against the master mask, unmapped addresses above the main bytes, and a same-cycle read/write collision, where a design with write-first read logic would return the new byte.

// File: rtl/ctl_pkg.sv
// Shared definitions for the multi-group control register file.
// Bit positions of the main control byte are fixed because the decoded
// outputs and the global controls depend on them.
package ctl_pkg;
    localparam int BIT_BCAST = 7;  // group 0 only: broadcast window mapping
    localparam int BIT_OEN   = 6;  // group 0 only: output enable
    localparam int BIT_MMASK = 5;  // group 0 only: master interrupt mask
    localparam int BIT_MASKB = 4;  // detector B mask
    localparam int BIT_MASKA = 3;  // detector A mask
    localparam int BIT_FMT   = 2;  // 1 = G.711, 0 = sign-magnitude
    localparam int BIT_LAW   = 1;  // 1 = A-law, 0 = mu-law
    localparam int BIT_PWR   = 0;  // power-up

    localparam logic [7:0] LOCAL_BITS = 8'h1F;  // bits stored in groups 1..N-1

    typedef enum logic [1:0] {
        RGN_WIN  = 2'd0,
        RGN_MAIN = 2'd1,
        RGN_NONE = 2'd2
    } rgn_e;
endpackage

// File: rtl/ctl_addr_decode.sv
// Address decoder: splits a host address into region, group and offset.
// Assumes NUM_GROUPS*WIN_DEPTH is a power of two and that the main bytes
// sit directly above the windows.
module ctl_addr_decode
    import ctl_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    parameter int WIN_DEPTH  = 64,
    localparam int OFF_W  = $clog2(WIN_DEPTH),
    localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int ADDR_W = $clog2(NUM_GROUPS * WIN_DEPTH) + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              region,
    output logic [GRP_W-1:0]  grp,
    output logic [OFF_W-1:0]  off
);
    // Classify the address and extract its group index and offset.
    always_comb begin
        off = addr[OFF_W-1:0];
        if (!addr[ADDR_W-1]) begin
            region = RGN_WIN;
            grp    = GRP_W'(addr[ADDR_W-2:OFF_W]);
        end else if (int'(addr[ADDR_W-2:0]) < NUM_GROUPS) begin
            region = RGN_MAIN;
            grp    = addr[GRP_W-1:0];
        end else begin
            region = RGN_NONE;
            grp    = '0;
        end
    end
endmodule

// File: rtl/ctl_win_bank.sv
// Per-group byte windows. Each group stores WIN_DEPTH bytes and is
// written when its bit in wr_mask is set; the caller resolves broadcast.
// Read is asynchronous for the addressed group and offset.
module ctl_win_bank #(
    parameter int NUM_GROUPS = 16,
    parameter int WIN_DEPTH  = 64,
    localparam int OFF_W = $clog2(WIN_DEPTH),
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] wr_mask,
    input  logic [OFF_W-1:0]      off,
    input  logic [7:0]            wdata,
    input  logic [GRP_W-1:0]      rd_grp,
    output logic [7:0]            rd_byte
);
    logic [NUM_GROUPS-1:0][7:0] grp_byte;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [7:0] mem [WIN_DEPTH];

        // Clear on reset, store the byte when this group is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WIN_DEPTH; i++) mem[i] <= '0;
            end else if (wr_mask[g]) begin
                mem[off] <= wdata;
            end
        end

        assign grp_byte[g] = mem[off];
    end

    assign rd_byte = grp_byte[rd_grp];
endmodule

// File: rtl/ctl_main_bank.sv
// Main control bytes, one per group. Group 0 keeps all eight bits;
// the others keep only the local bits, so global bits read as zero.
module ctl_main_bank
    import ctl_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [GRP_W-1:0]           idx,
    input  logic [7:0]                 wdata,
    output logic [NUM_GROUPS-1:0][7:0] main_q
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_main
        localparam logic [7:0] KEEP = (g == 0) ? 8'hFF : LOCAL_BITS;

        // Hold this group's main byte, masked to its implemented bits.
        always_ff @(posedge clk) begin
            if (!rst_n)                                main_q[g] <= '0;
            else if (wr_en && idx == GRP_W'(g))        main_q[g] <= wdata & KEEP;
        end
    end

    AST_MAIN_LOCAL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> main_q[$past(idx)][4:0] == $past(wdata[4:0])); // R3
endmodule

// File: rtl/ctl_irq_merge.sv
// Merges the per-group detector interrupts through their masks and the
// master mask into one registered active-high line.
module ctl_irq_merge
    import ctl_pkg::*;
#(
    parameter int NUM_GROUPS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GROUPS-1:0]      det_a,
    input  logic [NUM_GROUPS-1:0]      det_b,
    input  logic [NUM_GROUPS-1:0][7:0] main_q,
    output logic                       irq_q
);
    logic [NUM_GROUPS-1:0] live;

    // Per-group: a detector passes when its own mask bit is clear.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            live[g] = (det_a[g] && !main_q[g][BIT_MASKA]) ||
                      (det_b[g] && !main_q[g][BIT_MASKB]);
        end
    end

    // Register the merged request, forced low by the master mask.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (|live) && !main_q[0][BIT_MMASK];
    end

    AST_MASTER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        main_q[0][BIT_MMASK] |=> !irq_q); // R9
    AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (det_a == '0 && det_b == '0) |=> !irq_q); // R8
endmodule

// File: rtl/ctl_regfile_top.sv
// Multi-group control register file. Decodes the host address, steers
// writes into the windows (with group-0 broadcast) or the main bytes,
// returns read data one cycle after the strobe, and derives the enable,
// interrupt and per-group control outputs. Assumes one host access of
// each kind per cycle; a read in the same cycle as a write sees old data.
module ctl_regfile_top
    import ctl_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    parameter int WIN_DEPTH  = 64,
    localparam int OFF_W  = $clog2(WIN_DEPTH),
    localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int ADDR_W = $clog2(NUM_GROUPS * WIN_DEPTH) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [7:0]            host_wdata,
    input  logic                  host_wr,
    input  logic                  host_rd,
    output logic [7:0]            host_rdata,
    input  logic                  oe_pin,
    output logic                  oe_out,
    input  logic [NUM_GROUPS-1:0] tone_a_irq,
    input  logic [NUM_GROUPS-1:0] tone_b_irq,
    output logic                  irq_out,
    output logic [NUM_GROUPS-1:0] pwr_up,
    output logic [NUM_GROUPS-1:0] law_alaw,
    output logic [NUM_GROUPS-1:0] fmt_g711
);
    rgn_e                       region;
    logic [GRP_W-1:0]           grp;
    logic [OFF_W-1:0]           off;
    logic [NUM_GROUPS-1:0][7:0] main_q;
    logic [NUM_GROUPS-1:0]      win_wr_mask;
    logic [7:0]                 win_byte;
    logic                       bcast;
    logic                       win_hidden;

    ctl_addr_decode #(.NUM_GROUPS(NUM_GROUPS), .WIN_DEPTH(WIN_DEPTH)) u_dec (
        .addr(host_addr), .region(region), .grp(grp), .off(off)
    );

    assign bcast      = main_q[0][BIT_BCAST];
    assign win_hidden = bcast && (grp != '0);

    // Select which group windows take this write.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            win_wr_mask[g] = host_wr && (region == RGN_WIN) && !win_hidden &&
                             (bcast || grp == GRP_W'(g));
        end
    end

    ctl_win_bank #(.NUM_GROUPS(NUM_GROUPS), .WIN_DEPTH(WIN_DEPTH)) u_win (
        .clk(clk), .rst_n(rst_n), .wr_mask(win_wr_mask), .off(off),
        .wdata(host_wdata), .rd_grp(grp), .rd_byte(win_byte)
    );

    ctl_main_bank #(.NUM_GROUPS(NUM_GROUPS)) u_main (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr && region == RGN_MAIN),
        .idx(grp), .wdata(host_wdata), .main_q(main_q)
    );

    ctl_irq_merge #(.NUM_GROUPS(NUM_GROUPS)) u_irq (
        .clk(clk), .rst_n(rst_n), .det_a(tone_a_irq), .det_b(tone_b_irq),
        .main_q(main_q), .irq_q(irq_out)
    );

    // Capture read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            unique case (region)
                RGN_WIN:  host_rdata <= win_hidden ? 8'h00 : win_byte;
                RGN_MAIN: host_rdata <= main_q[grp];
                default:  host_rdata <= 8'h00;
            endcase
        end
    end

    // Decode per-group controls and the combined output enable.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            pwr_up[g]   = main_q[g][BIT_PWR];
            law_alaw[g] = main_q[g][BIT_LAW];
            fmt_g711[g] = main_q[g][BIT_FMT];
        end
        oe_out = main_q[0][BIT_OEN] && oe_pin;
    end

    AST_PIN_GATES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_pin |-> !oe_out); // R7
    AST_HIDDEN_WIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && region == RGN_WIN && bcast && grp != '0) |=> host_rdata == 8'h00); // R5
    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && region == RGN_NONE) |=> host_rdata == 8'h00); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd && !$past(host_rd)) |=> $stable(host_rdata)); // R2
endmodule

// File: tb/tb_ctl_regfile_top.sv
// Bench: behavioural reference model updated on each rising edge and
// compared against every output on each falling edge.
module tb_ctl_regfile_top;
    localparam int NG = 16;
    localparam int WD = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [10:0]   host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [7:0]    host_rdata;
    logic          oe_pin = 1'b0;
    logic          oe_out;
    logic [NG-1:0] tone_a_irq = '0;
    logic [NG-1:0] tone_b_irq = '0;
    logic          irq_out;
    logic [NG-1:0] pwr_up, law_alaw, fmt_g711;

    ctl_regfile_top dut (.*);

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    string irq_req = "R8";

    logic [7:0] ref_mem [NG][WD];
    logic [7:0] ref_main [NG];
    logic [7:0] m_rd;
    logic       m_irq;

    function automatic logic [7:0] ref_read(int a);
        if (a < NG * WD) begin
            if (ref_main[0][7] && (a / WD) != 0) return 8'h00;
            return ref_mem[a / WD][a % WD];
        end
        if (a < NG * WD + NG) return ref_main[a - NG * WD];
        return 8'h00;
    endfunction

    task automatic ref_write(int a, logic [7:0] d);
        if (a < NG * WD) begin
            if (ref_main[0][7]) begin
                if (a / WD == 0) for (int k = 0; k < NG; k++) ref_mem[k][a % WD] = d;
            end else begin
                ref_mem[a / WD][a % WD] = d;
            end
        end else if (a < NG * WD + NG) begin
            ref_main[a - NG * WD] = (a == NG * WD) ? d : (d & 8'h1F);
        end
    endtask

    // Reference model: state advance on the rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                ref_main[g] = 8'h00;
                for (int o = 0; o < WD; o++) ref_mem[g][o] = 8'h00;
            end
            m_rd = 8'h00;
            m_irq = 1'b0;
        end else begin
            logic acc;
            acc = 1'b0;
            for (int g = 0; g < NG; g++) begin
                if (tone_a_irq[g] && !ref_main[g][3]) acc = 1'b1;
                if (tone_b_irq[g] && !ref_main[g][4]) acc = 1'b1;
            end
            if (ref_main[0][5]) acc = 1'b0;
            m_irq = acc;
            if (host_rd) m_rd = ref_read(int'(host_addr));
            if (host_wr) ref_write(int'(host_addr), host_wdata);
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output on the falling edge.
    always @(negedge clk) begin
        if (ref_main[0] !== 8'hxx) begin
            logic [NG-1:0] ep, el, ef;
            for (int g = 0; g < NG; g++) begin
                ep[g] = ref_main[g][0];
                el[g] = ref_main[g][1];
                ef[g] = ref_main[g][2];
            end
            chk(cur_req, "host_rdata", 32'(host_rdata), 32'(m_rd));
            chk(irq_req, "irq_out", 32'(irq_out), 32'(m_irq));
            chk("R7", "oe_out", 32'(oe_out), 32'(ref_main[0][6] & oe_pin));
            chk("R3", "pwr_up", 32'(pwr_up), 32'(ep));
            chk("R3", "law_alaw", 32'(law_alaw), 32'(el));
            chk("R3", "fmt_g711", 32'(fmt_g711), 32'(ef));
        end
    end

    task automatic bus_wr(int a, logic [7:0] d);
        @(posedge clk); #2;
        host_addr = 11'(a); host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #2;
        host_wr = 1'b0;
    endtask

    task automatic bus_rd(int a);
        @(posedge clk); #2;
        host_addr = 11'(a); host_rd = 1'b1;
        @(posedge clk); #2;
        host_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    bit done = 1'b0;

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_up();
        end
    end

    initial begin
        cur_req = "R1";
        idle(4); rst_n = 1'b1; idle(3);

        cur_req = "R2";
        bus_wr(12'h005, 8'hA5); bus_wr(12'h3C7, 8'h3C); bus_wr(12'h1FF, 8'h77);
        bus_rd(12'h005); idle(2); bus_rd(12'h3C7); bus_rd(12'h1FF); bus_rd(12'h045); idle(2);

        cur_req = "R3";
        bus_wr(12'h401, 8'h07); bus_wr(12'h40F, 8'h05); bus_wr(12'h400, 8'h02);
        bus_rd(12'h401); bus_rd(12'h40F); idle(1);

        cur_req = "R6";
        oe_pin = 1'b1;
        bus_wr(12'h403, 8'hFF); bus_rd(12'h403); idle(1);
        bus_wr(12'h405, 8'h80); bus_wr(12'h145, 8'h11);
        bus_rd(12'h005); bus_rd(12'h145); bus_rd(12'h185);
        bus_wr(12'h406, 8'h20); tone_a_irq[6] = 1'b1; idle(3); tone_a_irq[6] = 1'b0; idle(2);

        cur_req = "R7";
        bus_wr(12'h400, 8'h40); idle(1); oe_pin = 1'b0; idle(2); oe_pin = 1'b1; idle(2);

        cur_req = "R8"; irq_req = "R8";
        tone_a_irq[2] = 1'b1; idle(3);
        bus_wr(12'h402, 8'h08); idle(2);
        tone_b_irq[2] = 1'b1; idle(2);
        bus_wr(12'h402, 8'h18); idle(2);
        tone_b_irq[9] = 1'b1; idle(2);
        tone_a_irq = '0; tone_b_irq = '0; idle(2);

        cur_req = "R9"; irq_req = "R9";
        tone_a_irq[7] = 1'b1; idle(2);
        bus_wr(12'h400, 8'h60); idle(3);
        bus_wr(12'h400, 8'h40); idle(2);
        tone_a_irq = '0; idle(2); irq_req = "R8";

        cur_req = "R4";
        bus_wr(12'h400, 8'hC0); bus_wr(12'h010, 8'h5A);
        bus_wr(12'h400, 8'h40);
        bus_rd(12'h010); bus_rd(12'h050); bus_rd(12'h3D0); bus_rd(12'h005);

        cur_req = "R5";
        bus_wr(12'h400, 8'hC0); bus_wr(12'h090, 8'h99);
        bus_rd(12'h090); bus_rd(12'h150); bus_rd(12'h010); bus_rd(12'h3C7);
        bus_wr(12'h400, 8'h40);
        bus_rd(12'h090); bus_rd(12'h150); bus_rd(12'h3C7);

        cur_req = "R10";
        bus_rd(12'h401); bus_wr(12'h410, 8'hEE); bus_wr(12'h7FF, 8'hEE);
        bus_rd(12'h410); bus_rd(12'h7FF); bus_rd(12'h400); bus_rd(12'h010);

        cur_req = "R11";
        @(posedge clk); #2;
        host_addr = 11'h020; host_wdata = 8'hC3; host_wr = 1'b1; host_rd = 1'b1;
        @(posedge clk); #2;
        host_wr = 1'b0; host_rd = 1'b0;
        idle(1); bus_rd(12'h020); idle(2);

        done = 1'b1;
        finish_up();
    end
endmodule